// File: doc/BRIEF.md
# Fast Page DRAM Controller

This block sits between a synchronous host and an asynchronous 256K x 4 page-mode DRAM. The host presents an 18-bit word address, a write flag and 4-bit write data with a request/ready handshake. Read data comes back with a one-cycle response pulse. On the memory side the controller drives active-low row strobe, column strobe, write enable and output enable. It also drives a 9-bit address bus that carries the row half and then the column half of the word address. The data path is split into an outbound word, an enable for the outbound drivers, and an inbound word.

Once a row has been strobed, the controller leaves it open. A later request to the same row is served by a column-only cycle. A request to another row raises the row strobe for the precharge count and then opens the new row. Writes use early-write sequencing: write enable falls before the column strobe, so the memory keeps its outputs off while the controller drives the shared pins. All strobe timings are clock counts set by parameters. A maximum row-open count closes the row even while hits keep coming. A close input lets the host return the device to the idle, all-strobes-high state.

Top module: `fpdram_ctrl`

## Requirements
- R1: After reset all four strobes are high, the data drivers are off, `idle` is 1, `req_ready` is 1 and `rsp_valid` is 0.
- R2: The row half is `req_addr[17:9]` and is on `mem_addr` when the row strobe falls. The column half is `req_addr[8:0]` and is on `mem_addr`, held for the cycle before, when the column strobe falls. A column strobe falls only while the row strobe is low. Requests are served in order.
- R3: Each read returns the last word written to that address (0 if never written) on `rsp_rdata`, with a one-cycle `rsp_valid` pulse, in request order. Writes produce no pulse.
- R4: A write column cycle is an early write. Write enable is low and held for at least one cycle before the column strobe falls. The data drivers are enabled and output enable is high. The outbound word stays unchanged while the column strobe is low.
- R5: The data drivers and a low output enable never coincide. The drivers are off in the cycle before output enable falls.
- R6: The column strobe falls exactly T_RCD+1 cycles after the row strobe falls. It stays low for exactly T_CAS cycles.
- R7: Within an open row the column strobe stays high at least T_CP cycles between pulses. The row strobe stays high at least T_RP cycles before it falls again.
- R8: Consecutive requests to the open row cause no row-strobe activity. Only column cycles are issued.
- R9: A request to a different row raises the row strobe, precharges, and then opens the new row before its column cycle.
- R10: No column cycle starts once the row has been low T_RAS_MAX cycles. The row then closes, so a low period never exceeds max(T_RAS_MAX, T_RCD+1)+1+T_CAS+T_CP cycles.
- R11: While `close_row` is 1, `req_ready` is 0. Any column cycle in progress completes, after which the row and column strobes are high and `idle` becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address, row in upper half |
| req_wdata | input | 4 | Write word |
| rsp_valid | output | 1 | One-cycle pulse: read word is valid |
| rsp_rdata | output | 4 | Read word |
| close_row | input | 1 | Request to close the open row and go idle |
| idle | output | 1 | No row open, precharge complete |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_addr | output | 9 | Multiplexed row/column address |
| mem_dq_out | output | 4 | Word driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the outbound data drivers |
| mem_dq_in | input | 4 | Word read from the memory |

## Verification
The assertions assume a few things about the memory and the host. The memory returns stable read data on `mem_dq_in` while the column strobe and output enable are both low. The host changes `req_*` and `close_row` only between clock edges, and keeps a request steady until it is accepted. The bench drives every input at the falling clock edge and holds a request until it sees `req_ready`. It uses a pin-level memory model that latches the row and column at the strobe edges and answers reads combinationally. Random traffic is confined to a handful of rows so that page hits, misses and forced row closes all occur often.

// File: rtl/fpd_pkg.sv
package fpd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROWSET,
        ST_PRE,
        ST_RCD,
        ST_COLSET,
        ST_CAS,
        ST_CP,
        ST_OPEN
    } fpd_state_e;

endpackage

// File: rtl/fpd_timer.sv
module fpd_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/fpd_row_track.sv
module fpd_row_track #(
    parameter int RW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          open_en,
    input  logic          close_en,
    input  logic [RW-1:0] open_row,
    input  logic [RW-1:0] cmp_row,
    output logic          hit
);

    logic          vld_d, vld_q;
    logic [RW-1:0] row_d, row_q;

    always_comb begin
        vld_d = vld_q;
        row_d = row_q;
        if (open_en) begin
            vld_d = 1'b1;
            row_d = open_row;
        end else if (close_en) begin
            vld_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            row_q <= '0;
        end else begin
            vld_q <= vld_d;
            row_q <= row_d;
        end
    end

    assign hit = vld_q && (row_q == cmp_row);

endmodule

// File: rtl/fpd_ras_window.sv
module fpd_ras_window #(
    parameter int CW    = 8,
    parameter int LIMIT = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ras_low_next,
    output logic [CW-1:0] low_cnt,
    output logic          expired
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = ras_low_next ? cnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign low_cnt = cnt_q;
    assign expired = (cnt_q >= CW'(LIMIT));

endmodule

// File: rtl/fpdram_ctrl.sv
module fpdram_ctrl
    import fpd_pkg::*;
#(
    parameter int MW        = 9,
    parameter int DW        = 4,
    parameter int T_RCD     = 2,
    parameter int T_CAS     = 2,
    parameter int T_CP      = 1,
    parameter int T_RP      = 3,
    parameter int T_RAS_MAX = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [2*MW-1:0]  req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_rdata,
    input  logic             close_row,
    output logic             idle,
    output logic             mem_ras_n,
    output logic             mem_cas_n,
    output logic             mem_we_n,
    output logic             mem_oe_n,
    output logic [MW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_dq_out,
    output logic             mem_dq_oe,
    input  logic [DW-1:0]    mem_dq_in
);

    localparam int AW     = 2 * MW;
    localparam int TM_A   = (T_RCD > T_CAS) ? T_RCD : T_CAS;
    localparam int TM_B   = (T_CP > T_RP) ? T_CP : T_RP;
    localparam int TMAX   = (TM_A > TM_B) ? TM_A : TM_B;
    localparam int TW     = $clog2(TMAX + 1) + 1;
    localparam int CW     = $clog2(T_RAS_MAX + T_RCD + T_CAS + T_CP + 4) + 1;
    localparam int FIRSTC = T_RCD + 1;
    localparam int CASLIM = ((T_RAS_MAX > FIRSTC) ? T_RAS_MAX : FIRSTC) + 1;

    typedef struct packed {
        fpd_state_e     st;
        logic           ras_n;
        logic           cas_n;
        logic           we_n;
        logic           oe_n;
        logic [MW-1:0]  addr;
        logic [DW-1:0]  dq_out;
        logic           dq_oe;
        logic           pend_vld;
        logic           pend_wr;
        logic [AW-1:0]  pend_addr;
        logic [DW-1:0]  pend_wdata;
        logic           rsp_vld;
        logic [DW-1:0]  rdata;
    } ctl_t;

    ctl_t q, n;

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_done;
    logic          trk_open, trk_close, row_hit;
    logic [CW-1:0] ras_cnt;
    logic          ras_expired;

    fpd_timer #(.W(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    fpd_row_track #(.RW(MW)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .open_en  (trk_open),
        .close_en (trk_close),
        .open_row (q.pend_addr[AW-1:MW]),
        .cmp_row  (req_addr[AW-1:MW]),
        .hit      (row_hit)
    );

    fpd_ras_window #(.CW(CW), .LIMIT(T_RAS_MAX)) u_win (
        .clk          (clk),
        .rst_n        (rst_n),
        .ras_low_next (!n.ras_n),
        .low_cnt      (ras_cnt),
        .expired      (ras_expired)
    );

    assign req_ready = ((q.st == ST_IDLE) || (q.st == ST_OPEN)) && !close_row && !ras_expired;

    always_comb begin
        n         = q;
        n.rsp_vld = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        trk_open  = 1'b0;
        trk_close = 1'b0;
        case (q.st)
            ST_IDLE: begin
                n.ras_n = 1'b1;
                n.cas_n = 1'b1;
                if (req_valid && req_ready) begin
                    n.pend_vld   = 1'b1;
                    n.pend_wr    = req_write;
                    n.pend_addr  = req_addr;
                    n.pend_wdata = req_wdata;
                    n.addr       = req_addr[AW-1:MW];
                    n.st         = ST_ROWSET;
                end
            end
            ST_ROWSET: begin
                n.st     = ST_RCD;
                n.ras_n  = 1'b0;
                tmr_load = 1'b1;
                tmr_val  = TW'(T_RCD - 1);
                trk_open = 1'b1;
            end
            ST_PRE: begin
                if (tmr_done) begin
                    if (q.pend_vld) begin
                        n.st     = ST_RCD;
                        n.ras_n  = 1'b0;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(T_RCD - 1);
                        trk_open = 1'b1;
                    end else begin
                        n.st = ST_IDLE;
                    end
                end
            end
            ST_RCD: begin
                if (tmr_done) begin
                    n.st     = ST_COLSET;
                    n.addr   = q.pend_addr[MW-1:0];
                    n.we_n   = !q.pend_wr;
                    n.dq_out = q.pend_wdata;
                    n.dq_oe  = q.pend_wr;
                end
            end
            ST_COLSET: begin
                n.st     = ST_CAS;
                n.cas_n  = 1'b0;
                n.oe_n   = q.pend_wr;
                tmr_load = 1'b1;
                tmr_val  = TW'(T_CAS - 1);
            end
            ST_CAS: begin
                if (tmr_done) begin
                    n.st       = ST_CP;
                    n.cas_n    = 1'b1;
                    n.oe_n     = 1'b1;
                    n.we_n     = 1'b1;
                    n.dq_oe    = 1'b0;
                    n.pend_vld = 1'b0;
                    if (!q.pend_wr) begin
                        n.rdata   = mem_dq_in;
                        n.rsp_vld = 1'b1;
                    end
                    tmr_load = 1'b1;
                    tmr_val  = TW'(T_CP - 1);
                end
            end
            ST_CP: begin
                if (tmr_done) n.st = ST_OPEN;
            end
            ST_OPEN: begin
                if (close_row || ras_expired) begin
                    n.st       = ST_PRE;
                    n.ras_n    = 1'b1;
                    n.pend_vld = 1'b0;
                    tmr_load   = 1'b1;
                    tmr_val    = TW'(T_RP - 1);
                    trk_close  = 1'b1;
                end else if (req_valid) begin
                    n.pend_vld   = 1'b1;
                    n.pend_wr    = req_write;
                    n.pend_addr  = req_addr;
                    n.pend_wdata = req_wdata;
                    if (row_hit) begin
                        n.st     = ST_COLSET;
                        n.addr   = req_addr[MW-1:0];
                        n.we_n   = !req_write;
                        n.dq_out = req_wdata;
                        n.dq_oe  = req_write;
                    end else begin
                        n.st      = ST_PRE;
                        n.ras_n   = 1'b1;
                        n.addr    = req_addr[AW-1:MW];
                        tmr_load  = 1'b1;
                        tmr_val   = TW'(T_RP - 1);
                        trk_close = 1'b1;
                    end
                end
            end
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q            <= '0;
            q.st         <= ST_IDLE;
            q.ras_n      <= 1'b1;
            q.cas_n      <= 1'b1;
            q.we_n       <= 1'b1;
            q.oe_n       <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign idle       = (q.st == ST_IDLE);
    assign mem_ras_n  = q.ras_n;
    assign mem_cas_n  = q.cas_n;
    assign mem_we_n   = q.we_n;
    assign mem_oe_n   = q.oe_n;
    assign mem_addr   = q.addr;
    assign mem_dq_out = q.dq_out;
    assign mem_dq_oe  = q.dq_oe;
    assign rsp_valid  = q.rsp_vld;
    assign rsp_rdata  = q.rdata;

    assert_col_under_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cas_n) |-> (!mem_ras_n && $stable(mem_addr)));

    assert_we_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cas_n) |-> $stable(mem_we_n));

    assert_early_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cas_n && !mem_we_n) |-> (mem_dq_oe && mem_oe_n && $stable(mem_dq_out)));

    assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n));

    assert_turnaround_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe));

    assert_col_precharge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_cas_n) |=> mem_cas_n);

    assert_read_response_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(!mem_cas_n) && $past(mem_we_n)));

    assert_row_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cas_n) |-> (ras_cnt <= CW'(CASLIM)));

    assert_idle_closed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (mem_ras_n && mem_cas_n));

endmodule

// File: tb/sim_fpdram_ctrl.sv
module sim_fpdram_ctrl;

    localparam int T_RCD     = 2;
    localparam int T_CAS     = 2;
    localparam int T_CP      = 1;
    localparam int T_RP      = 3;
    localparam int T_RAS_MAX = 40;
    localparam int RAS_LIM   = ((T_RAS_MAX > T_RCD + 1) ? T_RAS_MAX : T_RCD + 1) + 1 + T_CAS + T_CP;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [3:0]  rsp_rdata;
    logic        close_row = 1'b0;
    logic        idle;
    logic        mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n;
    logic [8:0]  mem_addr;
    logic [3:0]  mem_dq_out;
    logic        mem_dq_oe;
    logic [3:0]  mem_dq_in;

    always #4 clk = ~clk;

    fpdram_ctrl #(
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .close_row(close_row), .idle(idle),
        .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int checks = 0;
    int fails  = 0;
    int reads_issued = 0;
    int rsp_seen = 0;
    int ras_falls = 0;

    logic [3:0]  dmem   [logic [17:0]];
    logic [3:0]  shadow [logic [17:0]];
    logic [17:0] addr_q [$];
    logic [3:0]  rd_q   [$];
    logic [3:0]  rd_word = '0;

    assign mem_dq_in = (!mem_cas_n && !mem_oe_n) ? rd_word : 4'h0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // pin-level memory model and timing monitor, sampled on falling edges
    logic       p_ras = 1'b1, p_cas = 1'b1, p_oe = 1'b1, p_dqoe = 1'b0;
    int         ras_low_c = 0, ras_high_c = 0, cas_low_c = 0, cas_high_c = 0;
    bit         seen_ras = 1'b0, first_col = 1'b0, wr_cycle = 1'b0;
    logic [8:0] lat_row = '0;
    logic [3:0] wr_word = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            // row strobe
            if (p_ras && !mem_ras_n) begin
                if (seen_ras) chk(ras_high_c >= T_RP, "R7 row precharge", ras_high_c, T_RP);
                seen_ras  = 1'b1;
                lat_row   = mem_addr;
                ras_falls++;
                ras_low_c = 1;
                first_col = 1'b1;
                cas_high_c = 0;
            end else if (!p_ras && mem_ras_n) begin
                chk(ras_low_c <= RAS_LIM, "R10 row low period", ras_low_c, RAS_LIM);
                ras_high_c = 1;
            end else if (!mem_ras_n) begin
                ras_low_c++;
            end else begin
                ras_high_c++;
            end
            // column strobe
            if (p_cas && !mem_cas_n) begin
                chk(!mem_ras_n, "R2 column under row", mem_ras_n, 0);
                if (first_col) chk(ras_low_c == T_RCD + 2, "R6 row-to-column", ras_low_c - 1, T_RCD + 1);
                else           chk(cas_high_c >= T_CP, "R7 column precharge", cas_high_c, T_CP);
                first_col = 1'b0;
                if (addr_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected column cycle", 0, 1);
                end else begin
                    logic [17:0] ea;
                    ea = addr_q.pop_front();
                    chk({lat_row, mem_addr} == ea, "R2 strobed address", {lat_row, mem_addr}, ea);
                end
                if (!mem_we_n) begin
                    chk(mem_dq_oe && mem_oe_n, "R4 early write pins", {mem_dq_oe, mem_oe_n}, 2'b11);
                    dmem[{lat_row, mem_addr}] = mem_dq_out;
                    wr_word  = mem_dq_out;
                    wr_cycle = 1'b1;
                end else begin
                    rd_word  = dmem.exists({lat_row, mem_addr}) ? dmem[{lat_row, mem_addr}] : 4'h0;
                    wr_cycle = 1'b0;
                end
                cas_low_c = 1;
            end else if (!p_cas && mem_cas_n) begin
                chk(cas_low_c == T_CAS, "R6 column low width", cas_low_c, T_CAS);
                cas_high_c = 1;
            end else if (!mem_cas_n) begin
                cas_low_c++;
                if (wr_cycle) chk(mem_dq_out == wr_word, "R4 write data hold", mem_dq_out, wr_word);
            end else begin
                cas_high_c++;
            end
            // data bus turnaround
            if (p_oe && !mem_oe_n) chk(!p_dqoe, "R5 drivers off before read", p_dqoe, 0);
            if (mem_dq_oe && !mem_oe_n) chk(1'b0, "R5 bus contention", 1, 0);
            // read responses
            if (rsp_valid) begin
                rsp_seen++;
                if (rd_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected response", rsp_rdata, 0);
                end else begin
                    logic [3:0] ed;
                    ed = rd_q.pop_front();
                    chk(rsp_rdata == ed, "R3 read data", rsp_rdata, ed);
                end
            end
            p_ras  = mem_ras_n;
            p_cas  = mem_cas_n;
            p_oe   = mem_oe_n;
            p_dqoe = mem_dq_oe;
        end
    end

    task automatic issue(input logic wr, input logic [17:0] a, input logic [3:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        addr_q.push_back(a);
        if (wr) begin
            shadow[a] = d;
        end else begin
            rd_q.push_back(shadow.exists(a) ? shadow[a] : 4'h0);
            reads_issued++;
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (addr_q.size() != 0 || rd_q.size() != 0) @(negedge clk);
        repeat (T_CAS + T_CP + 3) @(negedge clk);
    endtask

    task automatic do_close();
        @(negedge clk);
        close_row = 1'b1;
        @(negedge clk);
        chk(!req_ready, "R11 ready low while closing", req_ready, 0);
        while (!idle) @(negedge clk);
        chk(idle && mem_ras_n && mem_cas_n, "R11 closed and idle",
            {idle, mem_ras_n, mem_cas_n}, 3'b111);
        close_row = 1'b0;
    endtask

    task automatic run_test();
        int rf0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(mem_ras_n && mem_cas_n && mem_we_n && mem_oe_n, "R1 strobes high",
            {mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n}, 4'hf);
        chk(!mem_dq_oe, "R1 drivers off", mem_dq_oe, 0);
        chk(idle && req_ready && !rsp_valid, "R1 idle ready", {idle, req_ready, rsp_valid}, 3'b110);

        // R3 write then read, address extremes
        issue(1'b1, 18'h3ffff, 4'ha);
        issue(1'b1, 18'h00000, 4'h5);
        issue(1'b0, 18'h3ffff, 4'h0);
        issue(1'b0, 18'h00000, 4'h0);
        issue(1'b0, 18'h12345, 4'h0);
        drain();

        // R8 page hits in one row
        do_close();
        rf0 = ras_falls;
        issue(1'b1, {9'd5, 9'd1}, 4'h3);
        issue(1'b1, {9'd5, 9'd2}, 4'h6);
        issue(1'b0, {9'd5, 9'd1}, 4'h0);
        issue(1'b0, {9'd5, 9'd2}, 4'h0);
        drain();
        chk(ras_falls - rf0 == 1, "R8 single row open for hits", ras_falls - rf0, 1);

        // R9 miss to another row
        rf0 = ras_falls;
        issue(1'b0, {9'd6, 9'd7}, 4'h0);
        drain();
        chk(ras_falls - rf0 == 1, "R9 new row opened on miss", ras_falls - rf0, 1);
        chk(!mem_ras_n, "R9 new row left open", mem_ras_n, 0);

        // R10 forced close under continuous hits
        do_close();
        rf0 = ras_falls;
        for (int i = 0; i < 16; i++) issue(i[0], {9'd7, 9'(i)}, 4'(i));
        drain();
        chk(ras_falls - rf0 >= 2, "R10 row reopened after limit", ras_falls - rf0, 2);

        // random traffic over a few rows
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 24) == 0) begin
                do_close();
            end else begin
                logic [8:0] r, c;
                r = 9'($urandom_range(0, 3)) + 9'd200;
                c = 9'($urandom_range(0, 7));
                issue(1'($urandom_range(0, 1)), {r, c}, 4'($urandom_range(0, 15)));
                if ($urandom_range(0, 9) == 0) repeat (3) @(negedge clk);
            end
        end
        drain();
        do_close();
        chk(rsp_seen == reads_issued, "R3 one response per read", rsp_seen, reads_issued);
    endtask

    initial begin
        void'($urandom(32'd4242));
        fork
            run_test();
            begin
                repeat (150000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule